// File: doc/BRIEF.md
# Serial Scan Memory Test Controller

The controller lets a one-bit serial link exercise any one of sixteen on-chip memory banks. A 112-bit scan word is shifted in one bit per clock while scan is enabled. Once in place, the word's fields drive two memory ports: a read/write port (port 0) and a read-only port (port 1). Each port has an address, write data, active-low enable and write-enable fields, and a byte write mask. A four-bit bank number picks which bank the ports reach. A load strobe, given while scan is off, fires a single access. On the next clock, the data field of every port that performed a read is overwritten with the data that came back. The word is then shifted out on the serial output, most significant bit first, while the next command is shifted in behind it.

Banks 0 to 4 have both ports. The other bank numbers are reached through port 0 only, and a read on port 1 of such a bank always returns zero. A bank can be declared narrow: its read data is then zero-extended from a smaller width. The serial stream has no handshake. The master owns the clock and paces every bit, so there is no back-pressure and each clock with scan enabled moves exactly one bit.

Top module: `scan_mem_ctl`

## Requirements
- R1: A synchronous active-high reset clears the scan word to zero, except the two port enable-bar fields (bits 59 and 5), which become 1. The serial output always shows bit 111 of the word.
- R2: While scan_en is high, each clock shifts the word up one place and takes scan_in into bit 0, so the first bit sent ends in bit 111.
- R3: The fields sit in the word as follows. Bits 111:108 hold the bank number. Port 0 uses bits 107:92 (address), 91:60 (data), 59 (enable-bar), 58 (write-enable-bar) and 57:54 (mask). Port 1 uses bits 53:38 (address), 37:6 (data), 5 (enable-bar), 4 (write-enable-bar) and 3:0 (mask). Address, data, write-enable-bar and mask drive the port outputs at all times.
- R4: Every bank enable output stays 1 unless load is high while scan_en is low. A load given while scan_en is high causes no access and no capture.
- R5: During an access, only the enable bit of the selected bank follows that port's enable-bar field, and every other bit is 1. The port-1 enable bits of banks without a second port are always 1.
- R6: A port reads when its enable-bar field is 0 and its write-enable-bar field is 1. One clock after the load cycle, that port's data field takes the selected bank's read data, using the bank number held at the load. All other fields keep their values, and with no shift and no capture the word does not change.
- R7: A port that writes (write-enable-bar 0) or is disabled (enable-bar 1) keeps its data field through the capture.
- R8: A port-1 read of a bank without a second port (banks 5 to 15 by default) captures zero.
- R9: Read data from a narrow bank (bank 0, 8 bits wide by default) is captured zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the scan word and the memory access |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Shift enable |
| scan_in | input | 1 | Serial data in |
| load | input | 1 | Access strobe, effective while scan_en is low |
| scan_out | output | 1 | Serial data out (bit 111 of the word) |
| p0_addr | output | 16 | Port 0 address |
| p0_wdata | output | 32 | Port 0 write data |
| p0_web | output | 1 | Port 0 write enable, active low |
| p0_wmask | output | 4 | Port 0 byte write mask |
| p0_csb | output | 16 | Port 0 bank enables, active low, one bit per bank |
| p1_addr | output | 16 | Port 1 address |
| p1_wdata | output | 32 | Port 1 data field value |
| p1_web | output | 1 | Port 1 write enable field, active low |
| p1_wmask | output | 4 | Port 1 mask field |
| p1_csb | output | 16 | Port 1 bank enables, active low, one bit per bank |
| rd0_data | input | 512 | Port 0 read data, 32 bits per bank, bank i in bits 32i+31:32i |
| rd1_data | input | 512 | Port 1 read data, same packing |

## Verification
The assertions assume the following about the inputs:
- The banks return read data on the clock after an access, and that data stays unchanged until the capture edge.
- scan_en stays low in the cycle that follows a load. The shift property does not count a capture cycle as a shift cycle.

The stimulus keeps within these assumptions:
- Loads are always one cycle long, and scan_en is raised only after the capture edge.
- The bench's bank model registers read data on the access edge and leaves it unchanged otherwise.
- The only load given while scanning is held across a full shift, in order to show that it is ignored.

// File: rtl/scan_mem_pkg.sv
package scan_mem_pkg;
  localparam int SEL_W   = 4;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int MASK_W  = 4;
  localparam int NUM_MEM = 1 << SEL_W;
  localparam int PORT_W  = ADDR_W + DATA_W + 2 + MASK_W;
  localparam int WORD_W  = SEL_W + 2 * PORT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              csb;
    logic              web;
    logic [MASK_W-1:0] mask;
  } port_cmd_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    port_cmd_t        p0;
    port_cmd_t        p1;
  } scan_word_t;

  function automatic scan_word_t reset_word();
    scan_word_t w;
    w        = '0;
    w.p0.csb = 1'b1;
    w.p1.csb = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/scan_shift_reg.sv
module scan_shift_reg
  import scan_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_en,
  input  logic              scan_in,
  input  logic              cap0_en,
  input  logic              cap1_en,
  input  logic [DATA_W-1:0] cap0_data,
  input  logic [DATA_W-1:0] cap1_data,
  output scan_word_t        word
);
  logic capture;
  assign capture = cap0_en | cap1_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= reset_word();
    end else if (capture) begin
      if (cap0_en) word.p0.data <= cap0_data;
      if (cap1_en) word.p1.data <= cap1_data;
    end else if (scan_en) begin
      word <= scan_word_t'({word[WORD_W-2:0], scan_in});
    end
  end
endmodule

// File: rtl/scan_csb_decode.sv
module scan_csb_decode
  import scan_mem_pkg::*;
#(
  parameter logic [NUM_MEM-1:0] PRESENT_MAP = '1
) (
  input  logic               active,
  input  logic [SEL_W-1:0]   sel,
  input  logic               csb_field,
  output logic [NUM_MEM-1:0] csb_n
);
  logic enable;
  assign enable = active & ~csb_field;

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_bank
    assign csb_n[i] = ~(PRESENT_MAP[i] & enable & (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/scan_capture.sv
module scan_capture
  import scan_mem_pkg::*;
#(
  parameter logic [NUM_MEM-1:0] DUAL_MAP   = 16'h001F,
  parameter logic [NUM_MEM-1:0] NARROW_MAP = 16'h0001,
  parameter int                 NARROW_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_go,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      p0_csb_f,
  input  logic                      p0_web_f,
  input  logic                      p1_csb_f,
  input  logic                      p1_web_f,
  input  logic [NUM_MEM*DATA_W-1:0] rd0_flat,
  input  logic [NUM_MEM*DATA_W-1:0] rd1_flat,
  output logic                      cap0_en,
  output logic                      cap1_en,
  output logic [DATA_W-1:0]         cap0_data,
  output logic [DATA_W-1:0]         cap1_data
);
  localparam logic [DATA_W-1:0] NMASK = DATA_W'((64'd1 << NARROW_W) - 64'd1);

  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] r0 [NUM_MEM];
  logic [DATA_W-1:0] r1 [NUM_MEM];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap0_en <= 1'b0;
      cap1_en <= 1'b0;
      sel_q   <= '0;
    end else begin
      cap0_en <= load_go & ~p0_csb_f & p0_web_f;
      cap1_en <= load_go & ~p1_csb_f & p1_web_f;
      if (load_go) sel_q <= sel;
    end
  end

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_lane
    localparam logic [DATA_W-1:0] KEEP0 = NARROW_MAP[i] ? NMASK : '1;
    localparam logic [DATA_W-1:0] KEEP1 = DUAL_MAP[i] ? KEEP0 : '0;
    assign r0[i] = rd0_flat[i*DATA_W +: DATA_W] & KEEP0;
    assign r1[i] = rd1_flat[i*DATA_W +: DATA_W] & KEEP1;
  end

  assign cap0_data = r0[sel_q];
  assign cap1_data = r1[sel_q];
endmodule

// File: rtl/scan_mem_ctl.sv
module scan_mem_ctl
  import scan_mem_pkg::*;
#(
  parameter logic [15:0] DUAL_MAP   = 16'h001F,
  parameter logic [15:0] NARROW_MAP = 16'h0001,
  parameter int          NARROW_W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic         load,
  output logic         scan_out,
  output logic [15:0]  p0_addr,
  output logic [31:0]  p0_wdata,
  output logic         p0_web,
  output logic [3:0]   p0_wmask,
  output logic [15:0]  p0_csb,
  output logic [15:0]  p1_addr,
  output logic [31:0]  p1_wdata,
  output logic         p1_web,
  output logic [3:0]   p1_wmask,
  output logic [15:0]  p1_csb,
  input  logic [511:0] rd0_data,
  input  logic [511:0] rd1_data
);
  scan_word_t        word;
  logic              load_go;
  logic              cap0_en, cap1_en;
  logic [DATA_W-1:0] cap0_data, cap1_data;

  assign load_go = load & ~scan_en;

  scan_shift_reg u_shift (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .cap0_en   (cap0_en),
    .cap1_en   (cap1_en),
    .cap0_data (cap0_data),
    .cap1_data (cap1_data),
    .word      (word)
  );

  scan_capture #(
    .DUAL_MAP   (DUAL_MAP),
    .NARROW_MAP (NARROW_MAP),
    .NARROW_W   (NARROW_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .load_go   (load_go),
    .sel       (word.sel),
    .p0_csb_f  (word.p0.csb),
    .p0_web_f  (word.p0.web),
    .p1_csb_f  (word.p1.csb),
    .p1_web_f  (word.p1.web),
    .rd0_flat  (rd0_data),
    .rd1_flat  (rd1_data),
    .cap0_en   (cap0_en),
    .cap1_en   (cap1_en),
    .cap0_data (cap0_data),
    .cap1_data (cap1_data)
  );

  scan_csb_decode #(.PRESENT_MAP('1)) u_dec0 (
    .active    (load_go),
    .sel       (word.sel),
    .csb_field (word.p0.csb),
    .csb_n     (p0_csb)
  );

  scan_csb_decode #(.PRESENT_MAP(DUAL_MAP)) u_dec1 (
    .active    (load_go),
    .sel       (word.sel),
    .csb_field (word.p1.csb),
    .csb_n     (p1_csb)
  );

  assign scan_out = word[WORD_W-1];
  assign p0_addr  = word.p0.addr;
  assign p0_wdata = word.p0.data;
  assign p0_web   = word.p0.web;
  assign p0_wmask = word.p0.mask;
  assign p1_addr  = word.p1.addr;
  assign p1_wdata = word.p1.data;
  assign p1_web   = word.p1.web;
  assign p1_wmask = word.p1.mask;
endmodule

// File: rtl/scan_mem_ctl_chk.sv
module scan_mem_ctl_chk
  import scan_mem_pkg::*;
#(
  parameter logic [15:0] DUAL_MAP = 16'h001F
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_en,
  input logic              scan_in,
  input logic              load,
  input logic [15:0]       p0_csb,
  input logic [15:0]       p1_csb,
  input logic [WORD_W-1:0] word_q
);
  AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> word_q == WORD_W'(reset_word())); // R1

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !$past(load && !scan_en)) |=>
      (word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0])) && (word_q[0] == $past(scan_in))); // R2

  AST_NO_IDLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (scan_en || !load) |-> ((&p0_csb) && (&p1_csb))); // R4

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~p0_csb) && $onehot0(~p1_csb)); // R5

  AST_SINGLE_PORT_BANKS: assert property (@(posedge clk) disable iff (rst)
    (p1_csb | DUAL_MAP) == 16'hFFFF); // R5

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !$past(load && !scan_en)) |=> $stable(word_q)); // R6
endmodule

bind scan_mem_ctl scan_mem_ctl_chk #(.DUAL_MAP(DUAL_MAP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scan_en (scan_en),
  .scan_in (scan_in),
  .load    (load),
  .p0_csb  (p0_csb),
  .p1_csb  (p1_csb),
  .word_q  (word)
);

// File: tb/scan_mem_ctl_bench.sv
module scan_mem_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_en = 1'b0;
  logic         scan_in = 1'b0;
  logic         load = 1'b0;
  logic         scan_out;
  logic [15:0]  p0_addr, p1_addr;
  logic [31:0]  p0_wdata, p1_wdata;
  logic         p0_web, p1_web;
  logic [3:0]   p0_wmask, p1_wmask;
  logic [15:0]  p0_csb, p1_csb;
  logic [511:0] rd0_data, rd1_data;

  int checks = 0;
  int errors = 0;
  int idle_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_mem_ctl u_scan_mem_ctl (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in), .load(load),
    .scan_out(scan_out),
    .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_web(p0_web), .p0_wmask(p0_wmask), .p0_csb(p0_csb),
    .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_web(p1_web), .p1_wmask(p1_wmask), .p1_csb(p1_csb),
    .rd0_data(rd0_data), .rd1_data(rd1_data)
  );

  // Behavioural banks: 16 words each, read data registered on the access edge.
  logic [31:0] mem [16][16];
  logic [31:0] d0 [16];
  logic [31:0] d1 [16];

  always @(posedge clk) begin
    for (int i = 0; i < 16; i++) begin
      if (rst) begin
        d0[i] <= 32'hDEADBEEF;
        d1[i] <= 32'hDEADBEEF;
      end else begin
        if (!p0_csb[i]) begin
          if (!p0_web) begin
            for (int b = 0; b < 4; b++)
              if (p0_wmask[b]) mem[i][p0_addr[3:0]][8*b +: 8] <= p0_wdata[8*b +: 8];
          end else begin
            d0[i] <= mem[i][p0_addr[3:0]];
          end
        end
        if (!p1_csb[i]) d1[i] <= mem[i][p1_addr[3:0]];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      rd0_data[32*i +: 32] = d0[i];
      rd1_data[32*i +: 32] = d1[i];
    end
  end

  function automatic logic [111:0] mk(input logic [3:0] sel,
      input logic [15:0] a0, input logic [31:0] x0, input logic c0, input logic w0, input logic [3:0] m0,
      input logic [15:0] a1, input logic [31:0] x1, input logic c1, input logic w1, input logic [3:0] m1);
    return {sel, a0, x0, c0, w0, m0, a1, x1, c1, w1, m1};
  endfunction

  task automatic check(input string req, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [111:0] win, input bit hold_load, output logic [111:0] wout);
    scan_en = 1'b1;
    load = hold_load;
    for (int j = 0; j < 112; j++) begin
      wout[111-j] = scan_out;
      scan_in = win[111-j];
      #1;
      if (!((&p0_csb) && (&p1_csb))) idle_bad++;
      @(posedge clk);
      @(negedge clk);
    end
    load = 1'b0;
    scan_en = 1'b0;
  endtask

  task automatic do_load(output logic [15:0] c0, output logic [15:0] c1);
    load = 1'b1;
    #1;
    c0 = p0_csb;
    c1 = p1_csb;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [111:0] rst_word;
  assign rst_word = mk(4'd0, 16'd0, 32'd0, 1'b1, 1'b0, 4'd0, 16'd0, 32'd0, 1'b1, 1'b0, 4'd0);

  task automatic t_reset();
    logic [111:0] o;
    check("R1 scan_out after reset", {111'd0, scan_out}, {111'd0, 1'b0});
    check("R4 enables idle after reset", {80'd0, p0_csb, p1_csb}, {80'd0, 32'hFFFF_FFFF});
    shift_word('0, 1'b0, o);
    check("R1 R2 reset word shifted out", o, rst_word);
  endtask

  task automatic t_fields();
    logic [111:0] o;
    logic [111:0] w;
    w = mk(4'd3, 16'h00A7, 32'h1111_2222, 1'b0, 1'b0, 4'hF, 16'h0042, 32'h3333_4444, 1'b1, 1'b1, 4'h5);
    shift_word(w, 1'b0, o);
    check("R3 port0 fields", {57'd0, p0_addr, p0_wdata, p0_web, p0_wmask},
          {57'd0, 16'h00A7, 32'h1111_2222, 1'b0, 4'hF});
    check("R3 port1 fields", {57'd0, p1_addr, p1_wdata, p1_web, p1_wmask},
          {57'd0, 16'h0042, 32'h3333_4444, 1'b1, 4'h5});
    check("R4 no access without load", {80'd0, p0_csb, p1_csb}, {80'd0, 32'hFFFF_FFFF});
    shift_word(w, 1'b0, o);
    check("R2 word returns unchanged", o, w);
  endtask

  task automatic t_roundtrip();
    logic [111:0] o, w1, w2, rd;
    logic [15:0] c0, c1;
    w1 = mk(4'd2, 16'd5, 32'hCAFE_0001, 1'b0, 1'b0, 4'hF, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0);
    w2 = mk(4'd2, 16'd6, 32'h0BAD_F00D, 1'b0, 1'b0, 4'hF, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0);
    rd = mk(4'd2, 16'd5, 32'h0, 1'b0, 1'b1, 4'd0, 16'd6, 32'h0, 1'b0, 1'b1, 4'd0);
    shift_word(w1, 1'b0, o);
    do_load(c0, c1);
    check("R5 port0 enables on write", {80'd0, c0, c1}, {80'd0, 16'hFFFB, 16'hFFFF});
    shift_word(w2, 1'b0, o);
    check("R7 write keeps data field", o, w1);
    do_load(c0, c1);
    shift_word(rd, 1'b0, o);
    check("R7 second write keeps word", o, w2);
    do_load(c0, c1);
    check("R5 both ports enable bank 2", {80'd0, c0, c1}, {80'd0, 16'hFFFB, 16'hFFFB});
    shift_word('0, 1'b0, o);
    check("R6 read captures both ports",
          o, mk(4'd2, 16'd5, 32'hCAFE_0001, 1'b0, 1'b1, 4'd0, 16'd6, 32'h0BAD_F00D, 1'b0, 1'b1, 4'd0));
  endtask

  task automatic t_single();
    logic [111:0] o;
    logic [15:0] c0, c1;
    shift_word(mk(4'd9, 16'd3, 32'h1357_9BDF, 1'b0, 1'b0, 4'hF, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0), 1'b0, o);
    do_load(c0, c1);
    shift_word(mk(4'd9, 16'd3, 32'h0, 1'b0, 1'b1, 4'd0, 16'd3, 32'h7777_7777, 1'b0, 1'b1, 4'd0), 1'b0, o);
    do_load(c0, c1);
    check("R5 R8 single-port bank enables", {80'd0, c0, c1}, {80'd0, 16'hFDFF, 16'hFFFF});
    shift_word('0, 1'b0, o);
    check("R8 port1 of single-port bank reads zero",
          o, mk(4'd9, 16'd3, 32'h1357_9BDF, 1'b0, 1'b1, 4'd0, 16'd3, 32'h0, 1'b0, 1'b1, 4'd0));
  endtask

  task automatic t_narrow();
    logic [111:0] o;
    logic [15:0] c0, c1;
    shift_word(mk(4'd0, 16'd2, 32'hA5A5_1234, 1'b0, 1'b0, 4'hF, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0), 1'b0, o);
    do_load(c0, c1);
    shift_word(mk(4'd0, 16'd2, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd0, 16'd2, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd0), 1'b0, o);
    do_load(c0, c1);
    shift_word('0, 1'b0, o);
    check("R9 narrow bank zero-extended",
          o, mk(4'd0, 16'd2, 32'h0000_0034, 1'b0, 1'b1, 4'd0, 16'd2, 32'h0000_0034, 1'b0, 1'b1, 4'd0));
  endtask

  task automatic t_disabled();
    logic [111:0] o, w;
    logic [15:0] c0, c1;
    shift_word(mk(4'd4, 16'd7, 32'h2468_ACE0, 1'b0, 1'b0, 4'hF, 16'd0, 32'd0, 1'b1, 1'b1, 4'd0), 1'b0, o);
    do_load(c0, c1);
    w = mk(4'd4, 16'd7, 32'h0, 1'b0, 1'b1, 4'd0, 16'd7, 32'h55AA_55AA, 1'b1, 1'b1, 4'd0);
    shift_word(w, 1'b0, o);
    do_load(c0, c1);
    check("R5 disabled port1 gives no enable", {80'd0, c0, c1}, {80'd0, 16'hFFEF, 16'hFFFF});
    shift_word('0, 1'b0, o);
    check("R7 disabled port keeps data field",
          o, mk(4'd4, 16'd7, 32'h2468_ACE0, 1'b0, 1'b1, 4'd0, 16'd7, 32'h55AA_55AA, 1'b1, 1'b1, 4'd0));
  endtask

  task automatic t_load_ignored();
    logic [111:0] o, w;
    w = mk(4'd1, 16'd1, 32'h9999_9999, 1'b0, 1'b1, 4'd0, 16'd1, 32'h8888_8888, 1'b0, 1'b1, 4'd0);
    shift_word(w, 1'b1, o);
    @(posedge clk);
    @(negedge clk);
    shift_word('0, 1'b0, o);
    check("R4 load during scan ignored", o, w);
    checks++;
    if (idle_bad != 0) begin
      errors++;
      $display("FAIL R4 enable active while shifting: actual=%0d expected=0", idle_bad);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_roundtrip();
    t_single();
    t_narrow();
    t_disabled();
    t_load_ignored();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule